// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches the stream of memory accesses made by load and store instructions and learns, for each instruction address, whether its accesses step through memory by a constant distance. A direct-mapped table is indexed by low bits of the instruction address. Each slot keeps an instruction tag, the address last touched, the step between the last two addresses and a small saturating confidence counter.

Once the same step has been seen often enough in a row, the block asks for a line ahead of demand. The target is the current address plus the step times a fixed look-ahead distance. Requests leave through a one-deep valid/ready register. A request that arrives while the previous one is still waiting is dropped, so demand traffic is never held back. The block fetches nothing itself; the consumer decides what to do with each request.

Top module: `pc_stride_prefetcher`

## Requirements
- R1: After reset, `pf_vld` is low and every table slot is empty.
- R2: An access whose instruction tag does not match its slot, or whose slot is empty, rewrites the slot with the new tag, the current address, a zero step and a zero count, and never produces a request.
- R3: On a tag hit where the new step (current address minus stored address) equals the stored step, the count rises by one and holds at its maximum, 3 for the default 2-bit counter.
- R4: On a tag hit with a different step, the count returns to zero with the default CLEAR policy, or drops by one (not below zero) with the DECAY policy.
- R5: Every hit stores the newly measured step and the current address, so a new constant step is learned from the next access onward.
- R6: A request is made only on a hit whose step matched and whose updated count is strictly greater than `CONF_MIN` (default 1); with defaults, the fourth access of a steady pattern is the first to produce one.
- R7: The requested address is the current address plus step times `DIST` (default 2), taken modulo 2^`ADDR_W`, so negative steps work.
- R8: A step of zero never produces a request, however high the count.
- R9: The slot index is `acc_pc[PC_LSB +: IDX_W]` (default bits 5:2) and the tag is the PC bits above it; two instructions sharing an index evict each other.
- R10: While `pf_vld` is high and `pf_rdy` is low, `pf_vld` stays high and `pf_addr` stays unchanged. A request produced during that time is discarded.
- R11: A request caused by an access sampled at one rising edge is shown on `pf_vld`/`pf_addr` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_addr | input | ADDR_W | Data address of the access |
| pf_vld | output | 1 | Prefetch request pending |
| pf_rdy | input | 1 | Consumer takes the request this cycle |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
On every cycle, the assertions check three things. A stalled request keeps its address. A request never appears without an access in the cycle before. An access that misses the table never raises a request. They also check that a written slot reads back as occupied. Only the bench scenarios can show the learning itself: the exact access on which the count first clears the threshold, the computed target for positive and negative steps, and the difference between the two mismatch policies. They also cover eviction between aliasing instructions, silence under a zero step, and the request that is dropped during a stall.

// File: rtl/spf_pkg.sv
package spf_pkg;

   typedef enum logic [0:0] {
      MISMATCH_CLEAR = 1'b0,
      MISMATCH_DECAY = 1'b1
   } mismatch_e;

endpackage

// File: rtl/spf_table.sv
module spf_table #(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 26,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_occ,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [ADDR_W-1:0] rd_last,
   output logic [ADDR_W-1:0] rd_step,
   output logic [CNT_W-1:0]  rd_cnt,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_last,
   input  logic [ADDR_W-1:0] wr_step,
   input  logic [CNT_W-1:0]  wr_cnt
);
   localparam int SLOTS = 1 << IDX_W;

   logic [SLOTS-1:0]  occ_q;
   logic [TAG_W-1:0]  tag_q  [SLOTS];
   logic [ADDR_W-1:0] last_q [SLOTS];
   logic [ADDR_W-1:0] step_q [SLOTS];
   logic [CNT_W-1:0]  cnt_q  [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_q[s] <= 1'b0;
         end else if (hit_wr) begin
            occ_q[s] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_wr) begin
            tag_q[s]  <= wr_tag;
            last_q[s] <= wr_last;
            step_q[s] <= wr_step;
            cnt_q[s]  <= wr_cnt;
         end
      end
   end

   assign rd_occ  = occ_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_last = last_q[rd_idx];
   assign rd_step = step_q[rd_idx];
   assign rd_cnt  = cnt_q[rd_idx];

   // R2
   slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> occ_q[$past(wr_idx)]);

endmodule

// File: rtl/spf_train.sv
module spf_train
   import spf_pkg::*;
#(
   parameter int        PC_W     = 32,
   parameter int        ADDR_W   = 32,
   parameter int        IDX_W    = 4,
   parameter int        PC_LSB   = 2,
   parameter int        CNT_W    = 2,
   parameter int        CONF_MIN = 1,
   parameter int        DIST     = 2,
   parameter mismatch_e POLICY   = MISMATCH_CLEAR,
   localparam int       TAG_W    = PC_W - PC_LSB - IDX_W
) (
   input  logic              acc_vld,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [IDX_W-1:0]  idx,
   input  logic              rd_occ,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [ADDR_W-1:0] rd_last,
   input  logic [ADDR_W-1:0] rd_step,
   input  logic [CNT_W-1:0]  rd_cnt,
   output logic              wr_en,
   output logic [TAG_W-1:0]  wr_tag,
   output logic [ADDR_W-1:0] wr_last,
   output logic [ADDR_W-1:0] wr_step,
   output logic [CNT_W-1:0]  wr_cnt,
   output logic              tag_hit,
   output logic              cand_vld,
   output logic [ADDR_W-1:0] cand_addr
);
   localparam logic [CNT_W-1:0]  CNT_TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0]  CNT_MIN = CNT_W'(CONF_MIN);
   localparam logic [ADDR_W-1:0] DIST_V  = ADDR_W'(DIST);

   logic [TAG_W-1:0]  pc_tag;
   logic [ADDR_W-1:0] new_step;
   logic              step_same;
   logic [CNT_W-1:0]  cnt_up;
   logic [CNT_W-1:0]  cnt_bad;

   assign idx       = acc_pc[PC_LSB +: IDX_W];
   assign pc_tag    = acc_pc[PC_W-1 -: TAG_W];
   assign tag_hit   = rd_occ && (rd_tag == pc_tag);
   assign new_step  = acc_addr - rd_last;
   assign step_same = (new_step == rd_step);
   assign cnt_up    = (rd_cnt == CNT_TOP) ? CNT_TOP : rd_cnt + 1'b1;

   if (POLICY == MISMATCH_DECAY) begin : g_decay
      assign cnt_bad = (rd_cnt == '0) ? '0 : rd_cnt - 1'b1;
   end else begin : g_clear
      assign cnt_bad = '0;
   end

   always_comb begin
      wr_en   = acc_vld;
      wr_tag  = pc_tag;
      wr_last = acc_addr;
      if (tag_hit) begin
         wr_step = new_step;
         wr_cnt  = step_same ? cnt_up : cnt_bad;
      end else begin
         wr_step = '0;
         wr_cnt  = '0;
      end
   end

   assign cand_vld  = acc_vld && tag_hit && step_same && (new_step != '0)
                      && (wr_cnt > CNT_MIN);
   assign cand_addr = acc_addr + new_step * DIST_V;

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_vld,
   input  logic [ADDR_W-1:0] cand_addr,
   output logic              pf_vld,
   input  logic              pf_rdy,
   output logic [ADDR_W-1:0] pf_addr
);
   logic take;

   assign take = cand_vld && (!pf_vld || pf_rdy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_vld  <= 1'b0;
         pf_addr <= '0;
      end else if (take) begin
         pf_vld  <= 1'b1;
         pf_addr <= cand_addr;
      end else if (pf_rdy) begin
         pf_vld  <= 1'b0;
      end
   end

   // R10
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_vld && !pf_rdy |=> pf_vld && $stable(pf_addr));

endmodule

// File: rtl/pc_stride_prefetcher.sv
module pc_stride_prefetcher
   import spf_pkg::*;
#(
   parameter int        PC_W     = 32,
   parameter int        ADDR_W   = 32,
   parameter int        IDX_W    = 4,
   parameter int        PC_LSB   = 2,
   parameter int        CNT_W    = 2,
   parameter int        CONF_MIN = 1,
   parameter int        DIST     = 2,
   parameter mismatch_e POLICY   = MISMATCH_CLEAR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              pf_vld,
   input  logic              pf_rdy,
   output logic [ADDR_W-1:0] pf_addr
);
   localparam int TAG_W   = PC_W - PC_LSB - IDX_W;
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   if (TAG_W < 1) begin : g_bad_tag
      $error("PC too narrow for index and alignment");
   end
   if (CONF_MIN < 0 || CONF_MIN >= CNT_TOP) begin : g_bad_conf
      $error("CONF_MIN must lie below the counter maximum");
   end
   if (DIST < 1) begin : g_bad_dist
      $error("DIST must be at least one");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("IDX_W out of range");
   end

   logic [IDX_W-1:0]  idx;
   logic              rd_occ;
   logic [TAG_W-1:0]  rd_tag;
   logic [ADDR_W-1:0] rd_last;
   logic [ADDR_W-1:0] rd_step;
   logic [CNT_W-1:0]  rd_cnt;
   logic              wr_en;
   logic [TAG_W-1:0]  wr_tag;
   logic [ADDR_W-1:0] wr_last;
   logic [ADDR_W-1:0] wr_step;
   logic [CNT_W-1:0]  wr_cnt;
   logic              tag_hit;
   logic              cand_vld;
   logic [ADDR_W-1:0] cand_addr;

   spf_table #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(idx), .rd_occ(rd_occ), .rd_tag(rd_tag), .rd_last(rd_last),
      .rd_step(rd_step), .rd_cnt(rd_cnt),
      .wr_en(wr_en), .wr_idx(idx), .wr_tag(wr_tag), .wr_last(wr_last),
      .wr_step(wr_step), .wr_cnt(wr_cnt)
   );

   spf_train #(
      .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB),
      .CNT_W(CNT_W), .CONF_MIN(CONF_MIN), .DIST(DIST), .POLICY(POLICY)
   ) u_train (
      .acc_vld(acc_vld), .acc_pc(acc_pc), .acc_addr(acc_addr), .idx(idx),
      .rd_occ(rd_occ), .rd_tag(rd_tag), .rd_last(rd_last),
      .rd_step(rd_step), .rd_cnt(rd_cnt),
      .wr_en(wr_en), .wr_tag(wr_tag), .wr_last(wr_last),
      .wr_step(wr_step), .wr_cnt(wr_cnt),
      .tag_hit(tag_hit), .cand_vld(cand_vld), .cand_addr(cand_addr)
   );

   spf_issue #(.ADDR_W(ADDR_W)) u_issue (
      .clk(clk), .rst_n(rst_n),
      .cand_vld(cand_vld), .cand_addr(cand_addr),
      .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr)
   );

   // R11
   req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_vld) |-> $past(acc_vld));

   // R2
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vld && !tag_hit && !pf_vld |=> !pf_vld);

endmodule

// File: tb/sim_pc_stride_prefetcher.sv
module sim_pc_stride_prefetcher;
   import spf_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic [31:0] acc_pc = '0;
   logic [31:0] acc_addr = '0;
   logic        pf_rdy = 1'b1;
   logic        pf_vld, pf_vld1;
   logic [31:0] pf_addr, pf_addr1;

   int vectors = 0;
   int misses  = 0;
   logic [31:0] expq [$];

   always #10 clk = ~clk;

   pc_stride_prefetcher u0 (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_pc(acc_pc),
      .acc_addr(acc_addr), .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr)
   );

   pc_stride_prefetcher #(.POLICY(MISMATCH_DECAY)) u1 (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_pc(acc_pc),
      .acc_addr(acc_addr), .pf_vld(pf_vld1), .pf_rdy(1'b1), .pf_addr(pf_addr1)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one access at the falling edge, check pf_vld after the next rising edge
   task automatic access(input logic [31:0] pc, input logic [31:0] addr,
                         input bit exp_vld, input bit push,
                         input logic [31:0] exp_addr, input string req);
      acc_vld  = 1'b1;
      acc_pc   = pc;
      acc_addr = addr;
      @(negedge clk);
      acc_vld = 1'b0;
      check(pf_vld == exp_vld, req, 32'(pf_vld), 32'(exp_vld));
      if (push) expq.push_back(exp_addr);
   endtask

   // monitor: compare each accepted request against the scoreboard
   always @(negedge clk) begin
      #1;
      if (rst_n && pf_vld && pf_rdy) begin
         if (expq.size() == 0) begin
            check(1'b0, "R6 unexpected request", pf_addr, 32'h0);
         end else begin
            logic [31:0] e;
            e = expq.pop_front();
            check(pf_addr == e, "R7 request address", pf_addr, e);
         end
      end
   end

   initial begin
      #(20ns * 100000);
      misses++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pf_vld == 1'b0, "R1 reset idle", 32'(pf_vld), 32'h0);

      // steady +0x40 pattern on PC 0x1000 (slot 0)
      access(32'h1000, 32'h8000, 0, 0, 0, "R2 first access allocates");
      access(32'h1000, 32'h8040, 0, 0, 0, "R4 new step clears count");
      access(32'h1000, 32'h8080, 0, 0, 0, "R6 count 1 not above threshold");
      access(32'h1000, 32'h80C0, 1, 1, 32'h8140, "R6 R11 first request");
      access(32'h1000, 32'h8100, 1, 1, 32'h8180, "R3 count rises");
      access(32'h1000, 32'h8140, 1, 1, 32'h81C0, "R3 count saturated");
      // break the step: CLEAR drops to 0, DECAY to 2
      access(32'h1000, 32'h9000, 0, 0, 0, "R4 mismatch no request");
      check(pf_vld1 == 1'b0, "R4 decay mismatch no request", 32'(pf_vld1), 32'h0);
      access(32'h1000, 32'h9EC0, 0, 0, 0, "R5 R4 relearn from zero");
      check(pf_vld1 == 1'b1, "R4 decay keeps confidence", 32'(pf_vld1), 32'h1);
      check(pf_addr1 == 32'hBC40, "R5 decay uses new step", pf_addr1, 32'hBC40);

      // negative step on PC 0x2004 (slot 1)
      access(32'h2004, 32'h5000, 0, 0, 0, "R2 alloc negative");
      access(32'h2004, 32'h4FF0, 0, 0, 0, "R4 negative first step");
      access(32'h2004, 32'h4FE0, 0, 0, 0, "R6 negative count 1");
      access(32'h2004, 32'h4FD0, 1, 1, 32'h4FB0, "R7 negative step target");

      // zero step on PC 0x3008 (slot 2)
      for (int k = 0; k < 5; k++)
         access(32'h3008, 32'h7000, 0, 0, 0, "R8 zero step silent");

      // aliasing: PC 0x1040 shares slot 0 with 0x1000
      access(32'h1040, 32'h0100, 0, 0, 0, "R9 alias evicts");
      access(32'h1000, 32'h9EC0 + 32'h0EC0, 0, 0, 0, "R9 evicted pc misses");
      access(32'h1000, 32'h9EC0 + 32'h1D80, 0, 0, 0, "R9 step relearned");

      // stall on PC 0x400C (slot 3)
      access(32'h400C, 32'h0000, 0, 0, 0, "R2 alloc stall pc");
      access(32'h400C, 32'h0010, 0, 0, 0, "R4 stall pc first step");
      access(32'h400C, 32'h0020, 0, 0, 0, "R6 stall pc count 1");
      pf_rdy = 1'b0;
      access(32'h400C, 32'h0030, 1, 1, 32'h0050, "R10 request while stalled");
      access(32'h400C, 32'h0040, 1, 0, 0, "R10 held during stall");
      check(pf_addr == 32'h0050, "R10 address held, new one dropped", pf_addr, 32'h0050);
      pf_rdy = 1'b1;
      @(negedge clk);
      check(pf_vld == 1'b0, "R10 released after handshake", 32'(pf_vld), 32'h0);

      @(negedge clk);
      check(expq.size() == 0, "R7 all requests seen", 32'(expq.size()), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule